// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block selects where each ALU operand of a five-stage, 32-register integer pipeline comes from. The instruction sitting in the execute stage names two source registers. Each source is compared against the destination registers of the two older instructions, which are held in the execute/memory and memory/writeback pipeline registers. When an older instruction will write the register being read, its result replaces the stale register-file value. The replacement is made before that result has reached the register file.

The block is purely combinational. For each operand it emits a 2-bit select code and the operand value that the code picks from three candidates. Register 0 is hard-wired to zero, so it is never forwarded. When both older stages target the same register, the younger result wins. Stall generation, the register file and the ALU belong to neighbouring logic.

Top module: `fwd_unit`

## Requirements
- R1: The select code means 2'b00 = register-file value, 2'b01 = memory/writeback result, 2'b10 = execute/memory result. Each operand output equals the candidate that its select code names.
- R2: Operand A selects 2'b10 when the execute/memory write enable is 1, its destination is nonzero, and its destination equals the execute-stage first source number.
- R3: Operand B selects 2'b10 under the R2 conditions, with the comparison made against the execute-stage second source number.
- R4: An operand selects 2'b01 when the memory/writeback write enable is 1, its destination is nonzero and equals that operand's source number, and R2/R3 does not apply to that operand.
- R5: When both older stages would forward to the same operand, the code is 2'b10, so the execute/memory result is used.
- R6: A source number of 0 always gives code 2'b00, whatever the destinations and write enables are.
- R7: A stage whose write enable is 0 never supplies an operand, even when its destination matches the source.
- R8: The two operands are resolved independently. In the same cycle, A may take one stage's result while B takes the other stage's result or the register-file value.
- R9: Select code 2'b11 is never produced on either operand.
- R10: Outputs follow input changes with no clock edge involved. Results settle in the same cycle as the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| ex_rdat_a | input | 32 | Register-file value read for the first source |
| ex_rdat_b | input | 32 | Register-file value read for the second source |
| em_wen | input | 1 | Execute/memory instruction writes a register |
| em_dst | input | 5 | Execute/memory destination register number |
| em_res | input | 32 | Execute/memory result value |
| mw_wen | input | 1 | Memory/writeback instruction writes a register |
| mw_dst | input | 5 | Memory/writeback destination register number |
| mw_res | input | 32 | Memory/writeback result value |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | 32 | Operand A delivered to the ALU |
| opnd_b | output | 32 | Operand B delivered to the ALU |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between input and output. The bench changes inputs on the falling clock edge and samples 2 ns later, well before the next rising edge, so no check depends on a clock. It sweeps all write-enable pairs against a set of register numbers that includes 0 and 31, and computes the expected codes and operands arithmetically. For R10 it changes an input between two samples that fall in the same clock cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_OPS = 2;

  typedef enum logic [1:0] {
    FSEL_REGF = 2'b00,
    FSEL_WB   = 2'b01,
    FSEL_MEM  = 2'b10,
    FSEL_RSVD = 2'b11
  } fsel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned AW = 5
) (
  input  logic          wen,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wen && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic  mem_hit,
  input  logic  wb_hit,
  output fsel_e sel
);
  always_comb begin
    if (mem_hit)     sel = FSEL_MEM;
    else if (wb_hit) sel = FSEL_WB;
    else             sel = FSEL_REGF;
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fsel_e         sel,
  input  logic [DW-1:0] regf,
  input  logic [DW-1:0] wb,
  input  logic [DW-1:0] mem,
  output logic [DW-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FSEL_WB:  opnd = wb;
      FSEL_MEM: opnd = mem;
      default:  opnd = regf;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned DW = DATA_W
) (
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [DW-1:0] ex_rdat_a,
  input  logic [DW-1:0] ex_rdat_b,
  input  logic          em_wen,
  input  logic [AW-1:0] em_dst,
  input  logic [DW-1:0] em_res,
  input  logic          mw_wen,
  input  logic [AW-1:0] mw_dst,
  input  logic [DW-1:0] mw_res,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int unsigned NOPS = NUM_OPS;

  logic [AW-1:0] src  [NOPS];
  logic [DW-1:0] rdat [NOPS];
  logic [DW-1:0] outv [NOPS];
  fsel_e         sel  [NOPS];
  logic          mhit [NOPS];
  logic          whit [NOPS];

  assign src[0]  = ex_src_a;
  assign src[1]  = ex_src_b;
  assign rdat[0] = ex_rdat_a;
  assign rdat[1] = ex_rdat_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_hit #(.AW(AW)) u_mem_hit (
      .wen (em_wen),
      .dst (em_dst),
      .src (src[g]),
      .hit (mhit[g])
    );

    fwd_hit #(.AW(AW)) u_wb_hit (
      .wen (mw_wen),
      .dst (mw_dst),
      .src (src[g]),
      .hit (whit[g])
    );

    fwd_pick u_pick (
      .mem_hit (mhit[g]),
      .wb_hit  (whit[g]),
      .sel     (sel[g])
    );

    fwd_opmux #(.DW(DW)) u_mux (
      .sel  (sel[g]),
      .regf (rdat[g]),
      .wb   (mw_res),
      .mem  (em_res),
      .opnd (outv[g])
    );
  end

  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
  assign opnd_a = outv[0];
  assign opnd_b = outv[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [DW-1:0] ex_rdat_a,
  input logic [DW-1:0] ex_rdat_b,
  input logic          em_wen,
  input logic [AW-1:0] em_dst,
  input logic [DW-1:0] em_res,
  input logic          mw_wen,
  input logic [AW-1:0] mw_dst,
  input logic [DW-1:0] mw_res,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b
);
  always_comb begin
    // R9
    sel_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("reserved select code seen");
    // R6
    zero_src_chk: assert ((ex_src_a != '0 || sel_a == 2'b00) &&
                          (ex_src_b != '0 || sel_b == 2'b00))
      else $error("register 0 forwarded");
    // R7
    idle_stages_chk: assert (em_wen || mw_wen ||
                             (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("forward with both write enables low");
    // R1
    opnd_a_route_chk: assert (opnd_a == (sel_a == 2'b10 ? em_res :
                                         sel_a == 2'b01 ? mw_res : ex_rdat_a))
      else $error("operand A does not match its select");
    // R1
    opnd_b_route_chk: assert (opnd_b == (sel_b == 2'b10 ? em_res :
                                         sel_b == 2'b01 ? mw_res : ex_rdat_b))
      else $error("operand B does not match its select");
    // R5
    younger_wins_chk: assert (!(em_wen && em_dst != '0 && em_dst == ex_src_a)
                              || sel_a == 2'b10)
      else $error("execute/memory match not honoured on A");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, em_dst = '0, mw_dst = '0;
  logic [DW-1:0] ex_rdat_a = '0, ex_rdat_b = '0, em_res = '0, mw_res = '0;
  logic          em_wen = 1'b0, mw_wen = 1'b0;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  fwd_unit uut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_rdat_a(ex_rdat_a), .ex_rdat_b(ex_rdat_b),
    .em_wen(em_wen), .em_dst(em_dst), .em_res(em_res),
    .mw_wen(mw_wen), .mw_dst(mw_dst), .mw_res(mw_res),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    if (em_wen && em_dst == s) return 2'b10;
    if (mw_wen && mw_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] exp_op(logic [1:0] c, logic [DW-1:0] rf);
    return (c == 2'b10) ? em_res : (c == 2'b01) ? mw_res : rf;
  endfunction

  function automatic string tag(logic [AW-1:0] s, bit is_b);
    bit eh, wh;
    eh = em_wen && em_dst == s;
    wh = mw_wen && mw_dst == s;
    if (s == 0) return "R6";
    if (eh && wh) return "R5";
    if (eh) return is_b ? "R3" : "R2";
    if (wh) return "R4";
    if (em_dst == s || mw_dst == s) return "R7";
    return "R1";
  endfunction

  task automatic check_all();
    logic [1:0] ea, eb;
    ea = exp_sel(ex_src_a);
    eb = exp_sel(ex_src_b);
    chk(tag(ex_src_a, 1'b0), "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk(tag(ex_src_b, 1'b1), "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk("R1", "opnd_a", opnd_a, exp_op(ea, ex_rdat_a));
    chk("R1", "opnd_b", opnd_b, exp_op(eb, ex_rdat_b));
    chk("R9", "no_code_11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, '0);
  endtask

  task automatic drive(int sa, int sb, int ed, int md, bit ew, bit mwv);
    @(negedge clk);
    ex_src_a  = AW'(sa);
    ex_src_b  = AW'(sb);
    em_dst    = AW'(ed);
    mw_dst    = AW'(md);
    em_wen    = ew;
    mw_wen    = mwv;
    ex_rdat_a = 32'hA100_0000 | DW'(sa);
    ex_rdat_b = 32'hB200_0000 | DW'(sb);
    em_res    = 32'hE300_0000 | DW'(ed);
    mw_res    = 32'h7400_0000 | DW'(md);
    #2;
  endtask

  initial begin
    int vals[6] = '{0, 1, 2, 3, 30, 31};
    // initial state: all inputs zero
    @(negedge clk); #2;
    chk("R1", "init sel_a", {30'd0, sel_a}, '0);
    chk("R1", "init sel_b", {30'd0, sel_b}, '0);

    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 6; k++)
            for (int l = 0; l < 6; l++) begin
              drive(vals[i], vals[j], vals[k], vals[l], w[1], w[0]);
              check_all();
            end

    // R8: A from execute/memory, B from memory/writeback
    drive(5, 9, 5, 9, 1'b1, 1'b1);
    chk("R8", "sel_a split", {30'd0, sel_a}, 32'd2);
    chk("R8", "sel_b split", {30'd0, sel_b}, 32'd1);
    chk("R8", "opnd_b split", opnd_b, mw_res);

    // R5 on operand B with register 31
    drive(4, 31, 31, 31, 1'b1, 1'b1);
    chk("R5", "sel_b both match", {30'd0, sel_b}, 32'd2);
    chk("R5", "opnd_b both match", opnd_b, em_res);

    // R6 with destination 0 and both enables high
    drive(0, 0, 0, 0, 1'b1, 1'b1);
    chk("R6", "sel_a reg0", {30'd0, sel_a}, '0);
    chk("R6", "opnd_b reg0", opnd_b, ex_rdat_b);

    // R10: change inputs inside one cycle, no clock edge
    drive(7, 8, 7, 3, 1'b1, 1'b0);
    chk("R10", "sel_a before change", {30'd0, sel_a}, 32'd2);
    em_dst = 5'd12;
    #1;
    chk("R10", "sel_a after change", {30'd0, sel_a}, '0);
    chk("R10", "opnd_a after change", opnd_a, ex_rdat_a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule